// File: doc/BRIEF.md
# Transient-Response Self-Test Sequencer

This block is a synchronous controller for a built-in transient-response test of analogue cells. It reads a small on-chip microcode store, one word per test. Each word holds the following:

- a stimulus pulse width;
- up to two sample instants;
- for each instant, the code that the response is expected to match;
- an end-of-program flag.

For each test the block first moves the cell's input multiplexer into test mode. It then drives a logic-level square pulse. At each sample instant it places the expected code on an output that feeds an external DAC. After a settling delay it reads the one-bit result of an external window comparator. The DAC, the comparator and the analogue cell are outside the block.

The results of all samples in a test are ANDed into a registered verdict. A one-cycle done strobe marks the end of each test. A sticky fail flag records any failing test until reset. While enabled, the program runs without stopping. It wraps to word zero after a word flagged as the last one, or after the final address.

Timing is counted in clock cycles. The pulse starts on the first cycle of the timebase, which is cycle 0. Sample instants are counted on the same timebase. Widths follow the example of a 100 ns pulse with one sample at 750 ns: at 125 MHz that is 13 and 94 cycles.

Top module: `trbist_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, the outputs are as follows: test-mode select 0, pulse 0, compare code 0, done 0, verdict 0, sticky fail 0.
- R2: The test-mode select is high for exactly one cycle before the pulse rises. It stays high throughout the pulse. It is low in the cycle in which done is high, so the cell returns to functional mode for at least one cycle between tests.
- R3: Each test produces one pulse that is high for exactly the number of cycles in the word's pulse-width field.
- R4: For a sample instant S, the compare code output takes the word's expected code on timebase cycle S+1 (the pulse rise is cycle 0). The code keeps that value until the next sample.
- R5: The comparator bit is read on the clock edge at which the new compare code has been held for SETTLE+1 cycles.
- R6: A sample is taken only when its time is nonzero and no earlier than the current timebase when its turn comes. The second sample must be at least SETTLE+2 cycles after the first. A sample that fails this test ends sampling for that word.
- R7: A test ends on the first cycle at or after the pulse has finished in which no sample is pending. Done is then high for exactly one cycle, on the following cycle. The verdict is the AND of the comparator bits read in that test, and is 1 for a word with no samples.
- R8: The sticky fail flag is set by any test whose verdict is 0. It stays set until reset.
- R9: Words run in address order. The next address is zero after a word whose end-of-program bit is set, or after address DEPTH-1.
- R10: If enable goes low during a test, that test still completes. The block then stays idle, with the select low and no pulse or done, and keeps its address. When enable returns, it runs the following word.
- R11: A synchronous reset during operation returns the sequence to word zero and clears the sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| cmp_pass_i | input | 1 | Window comparator result, 1 = inside window |
| tmux_o | output | 1 | Cell input multiplexer select, 1 = test mode |
| pulse_o | output | 1 | Stimulus pulse |
| cmp_code_o | output | CODE_W (6) | Expected-value code to the DAC |
| done_o | output | 1 | One-cycle end-of-test strobe |
| verdict_o | output | 1 | Registered result of the last test, 1 = pass |
| sticky_fail_o | output | 1 | Set by any failed test until reset |

## Verification
The bench models the comparator so that it reports a match only once the code has been stable for SETTLE+1 cycles. A sequencer that reads the comparator one edge early therefore records a failure. The program includes the following cases:

- a sample taken while the pulse is still high;
- a word with no samples, which must pass even while the comparator is forced to fail;
- a second sample placed too close to the first, which must be skipped rather than taken late;
- an end-of-program flag before the last address, which a design that ignores it would miss by running the unused word.

Done timing is checked against the later of the pulse end and the last read. Enable is dropped in the middle of a test, and reset is applied in the middle of the sequence. These catch designs that abort the test, lose the address, or keep a stale sticky flag.

// File: rtl/trbist_pkg.sv
package trbist_pkg;

    localparam int PW_W   = 8;   // pulse-width field bits
    localparam int ST_W   = 8;   // sample-time field bits
    localparam int CODE_W = 6;   // expected-code bits
    localparam int NSAMP  = 2;   // sample slots per word
    localparam int TB_W   = ((PW_W > ST_W) ? PW_W : ST_W) + 2;

    typedef struct packed {
        logic                          eop;
        logic [PW_W-1:0]               pw;
        logic [NSAMP-1:0][ST_W-1:0]    st;
        logic [NSAMP-1:0][CODE_W-1:0]  code;
    } uword_t;

    localparam int UW = $bits(uword_t);

    typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN, S_GAP} seq_st_t;

    function automatic uword_t mk_word(input logic eop,
                                       input logic [PW_W-1:0] pw,
                                       input logic [ST_W-1:0] s0,
                                       input logic [CODE_W-1:0] c0,
                                       input logic [ST_W-1:0] s1,
                                       input logic [CODE_W-1:0] c1);
        uword_t w;
        w.eop     = eop;
        w.pw      = pw;
        w.st[0]   = s0;
        w.code[0] = c0;
        w.st[1]   = s1;
        w.code[1] = c1;
        return w;
    endfunction

endpackage

// File: rtl/trbist_ucode.sv
module trbist_ucode
    import trbist_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter logic [DEPTH*UW-1:0] PROG = '0,
    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr_i,
    output uword_t        word_o
);

    logic [UW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign words[i] = PROG[i*UW +: UW];
    end

    assign word_o = uword_t'(words[addr_i]);

endmodule

// File: rtl/trbist_sampler.sv
module trbist_sampler
    import trbist_pkg::*;
#(
    parameter int SETTLE = 2,
    localparam int SC_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1),
    localparam int KW   = $clog2(NSAMP + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic                         active_i,
    input  logic [NSAMP-1:0][ST_W-1:0]   st_i,
    input  logic [NSAMP-1:0][CODE_W-1:0] code_i,
    input  logic [TB_W-1:0]              tb_i,
    input  logic                         pass_i,
    output logic [CODE_W-1:0]            code_o,
    output logic                         idle_o,
    output logic                         acc_o
);

    logic [KW-1:0]     k_q;
    logic              settling_q;
    logic [SC_W-1:0]   scnt_q;
    logic [ST_W-1:0]   cur_st;
    logic [CODE_W-1:0] cur_code;
    logic              no_more, hit;

    always_comb begin
        cur_st   = '0;
        cur_code = '0;
        for (int j = 0; j < NSAMP; j++) begin
            if (k_q == KW'(j)) begin
                cur_st   = st_i[j];
                cur_code = code_i[j];
            end
        end
    end

    assign no_more = (cur_st == '0) || (TB_W'(cur_st) < tb_i);
    assign hit     = active_i && !settling_q && !no_more && (TB_W'(cur_st) == tb_i);
    assign idle_o  = !settling_q && no_more;

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q        <= '0;
            settling_q <= 1'b0;
            scnt_q     <= '0;
            acc_o      <= 1'b0;
            code_o     <= '0;
        end else if (start_i) begin
            k_q        <= '0;
            settling_q <= 1'b0;
            scnt_q     <= '0;
            acc_o      <= 1'b1;
        end else if (active_i) begin
            if (hit) begin
                code_o     <= cur_code;
                settling_q <= 1'b1;
                scnt_q     <= '0;
            end else if (settling_q) begin
                if (scnt_q == SC_W'(SETTLE)) begin
                    acc_o      <= acc_o & pass_i;
                    settling_q <= 1'b0;
                    k_q        <= k_q + KW'(1);
                end else begin
                    scnt_q <= scnt_q + SC_W'(1);
                end
            end
        end
    end

    // R4
    code_only_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_o) |-> $past(active_i));

    // R5
    read_ends_settle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(settling_q) && !$past(start_i) |-> $past(active_i));

endmodule

// File: rtl/trbist_seq.sv
module trbist_seq
    import trbist_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int SETTLE = 2,
    parameter logic [DEPTH*UW-1:0] PROG =
        (DEPTH*UW)'(mk_word(1'b1, 8'd13, 8'd94, 6'd40, 8'd0, 6'd0)),
    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              cmp_pass_i,
    output logic              tmux_o,
    output logic              pulse_o,
    output logic [CODE_W-1:0] cmp_code_o,
    output logic              done_o,
    output logic              verdict_o,
    output logic              sticky_fail_o
);

    seq_st_t         state_q;
    logic [AW-1:0]   addr_q;
    logic [TB_W-1:0] tb_q;
    uword_t          word;
    logic            samp_idle, acc;
    logic            end_test;

    trbist_ucode #(.DEPTH(DEPTH), .PROG(PROG)) u_ucode (
        .addr_i (addr_q),
        .word_o (word)
    );

    trbist_sampler #(.SETTLE(SETTLE)) u_samp (
        .clk      (clk),
        .rst      (rst),
        .start_i  (state_q == S_ARM),
        .active_i (state_q == S_RUN),
        .st_i     (word.st),
        .code_i   (word.code),
        .tb_i     (tb_q),
        .pass_i   (cmp_pass_i),
        .code_o   (cmp_code_o),
        .idle_o   (samp_idle),
        .acc_o    (acc)
    );

    assign tmux_o   = (state_q == S_ARM) || (state_q == S_RUN);
    assign pulse_o  = (state_q == S_RUN) && (tb_q < TB_W'(word.pw));
    assign end_test = (state_q == S_RUN) && samp_idle && (tb_q >= TB_W'(word.pw));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= S_IDLE;
            addr_q        <= '0;
            tb_q          <= '0;
            done_o        <= 1'b0;
            verdict_o     <= 1'b0;
            sticky_fail_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                S_IDLE: if (en_i) state_q <= S_ARM;
                S_ARM: begin
                    tb_q    <= '0;
                    state_q <= S_RUN;
                end
                S_RUN: begin
                    tb_q <= tb_q + TB_W'(1);
                    if (end_test) begin
                        state_q   <= S_GAP;
                        done_o    <= 1'b1;
                        verdict_o <= acc;
                        if (!acc) sticky_fail_o <= 1'b1;
                        if (word.eop || addr_q == AW'(DEPTH - 1)) addr_q <= '0;
                        else                                     addr_q <= addr_q + AW'(1);
                    end
                end
                S_GAP: state_q <= en_i ? S_ARM : S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2
    gap_functional_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !tmux_o);

    // R2
    mux_before_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(tmux_o));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sticky_fail_o |=> sticky_fail_o);

    // R8
    fail_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_o && !verdict_o |-> sticky_fail_o);

endmodule

// File: tb/trbist_seq_test.sv
module trbist_seq_test;
    import trbist_pkg::*;

    localparam int DEPTH  = 5;
    localparam int SETTLE = 2;
    localparam logic [DEPTH*UW-1:0] PROG = {
        mk_word(1'b1, 8'd9, 8'd3,  6'd5,  8'd0,  6'd0),
        mk_word(1'b1, 8'd2, 8'd6,  6'd33, 8'd7,  6'd1),
        mk_word(1'b0, 8'd4, 8'd0,  6'd0,  8'd0,  6'd0),
        mk_word(1'b0, 8'd6, 8'd2,  6'd7,  8'd0,  6'd0),
        mk_word(1'b0, 8'd3, 8'd5,  6'd10, 8'd12, 6'd20)
    };

    typedef struct packed {
        logic [7:0] pw;
        logic [1:0] ns;
        logic [5:0] c0;
        logic [5:0] c1;
        logic [7:0] foff;
        logic [7:0] doff;
        logic       inj;
        logic       verdict;
        logic       sticky;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{8'd3, 2'd2, 6'd10, 6'd20, 8'd6, 8'd17, 1'b0, 1'b1, 1'b0},
        '{8'd6, 2'd1, 6'd7,  6'd0,  8'd3, 8'd7,  1'b0, 1'b1, 1'b0},
        '{8'd4, 2'd0, 6'd0,  6'd0,  8'd0, 8'd5,  1'b0, 1'b1, 1'b0},
        '{8'd2, 2'd1, 6'd33, 6'd0,  8'd7, 8'd11, 1'b0, 1'b1, 1'b0},
        '{8'd3, 2'd2, 6'd10, 6'd20, 8'd6, 8'd17, 1'b1, 1'b0, 1'b1},
        '{8'd6, 2'd1, 6'd7,  6'd0,  8'd3, 8'd7,  1'b0, 1'b1, 1'b1},
        '{8'd4, 2'd0, 6'd0,  6'd0,  8'd0, 8'd5,  1'b1, 1'b1, 1'b1},
        '{8'd2, 2'd1, 6'd33, 6'd0,  8'd7, 8'd11, 1'b0, 1'b1, 1'b1},
        '{8'd3, 2'd2, 6'd10, 6'd20, 8'd6, 8'd17, 1'b0, 1'b1, 1'b1},
        '{8'd6, 2'd1, 6'd7,  6'd0,  8'd3, 8'd7,  1'b0, 1'b1, 1'b1},
        '{8'd3, 2'd2, 6'd10, 6'd20, 8'd6, 8'd17, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic cmp_pass = 1'b0;
    logic tmux, pulse, done, verdict, sticky;
    logic [CODE_W-1:0] code;

    int n_run = 0;
    int n_fail = 0;
    logic inject = 1'b0;
    logic [CODE_W-1:0] last_code = '0;
    int held = 0;

    always #4 clk = ~clk;

    trbist_seq #(.DEPTH(DEPTH), .SETTLE(SETTLE), .PROG(PROG)) uut (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en),
        .cmp_pass_i    (cmp_pass),
        .tmux_o        (tmux),
        .pulse_o       (pulse),
        .cmp_code_o    (code),
        .done_o        (done),
        .verdict_o     (verdict),
        .sticky_fail_o (sticky)
    );

    // comparator model: matches only after the code has settled SETTLE+1 cycles
    always @(negedge clk) begin
        if (code != last_code) begin
            last_code = code;
            held = 1;
        end else if (held < 1000) begin
            held = held + 1;
        end
        cmp_pass = (held >= SETTLE + 1) && !inject;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_test(input int i);
        vec_t v;
        bit rise = 0;
        int off = 0, pcnt = 0, nchg = 0, first_off = -1;
        int c0 = 0, c1 = 0, guard = 0;
        bit bad_mux = 0, got_done = 0;
        logic p_tmux, p_pulse;
        logic [CODE_W-1:0] p_code;
        v = VEC[i];
        inject = v.inj;
        p_tmux = tmux; p_pulse = pulse; p_code = code;
        while (!got_done && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (rise) off++;
            if (pulse && !p_pulse) begin
                rise = 1;
                off = 0;
                chk(p_tmux == 1'b1, "R2 select before pulse", int'(p_tmux), 1);
            end
            if (pulse) pcnt++;
            if (pulse && !tmux) bad_mux = 1;
            if (code != p_code) begin
                nchg++;
                if (nchg == 1) begin first_off = off; c0 = int'(code); end
                if (nchg == 2) c1 = int'(code);
            end
            if (done) got_done = 1;
            p_tmux = tmux; p_pulse = pulse; p_code = code;
        end
        chk(got_done, "R7 done reached", int'(got_done), 1);
        chk(!bad_mux, "R2 select during pulse", int'(bad_mux), 0);
        chk(pcnt == int'(v.pw), "R3 pulse length", pcnt, int'(v.pw));
        chk(nchg == int'(v.ns), "R6 samples taken", nchg, int'(v.ns));
        if (v.ns >= 1) begin
            chk(first_off == int'(v.foff), "R4 code timing", first_off, int'(v.foff));
            chk(c0 == int'(v.c0), "R4 first code", c0, int'(v.c0));
        end
        if (v.ns == 2) chk(c1 == int'(v.c1), "R4 second code", c1, int'(v.c1));
        chk(off == int'(v.doff), "R7 done timing", off, int'(v.doff));
        chk(verdict == v.verdict, "R7 R5 verdict", int'(verdict), int'(v.verdict));
        chk(sticky == v.sticky, "R8 sticky", int'(sticky), int'(v.sticky));
        chk(tmux == 1'b0, "R2 functional at done", int'(tmux), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
        chk(tmux == en, "R9 R10 next start", int'(tmux), int'(en));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({tmux, pulse, done, verdict, sticky} == 5'b0, "R1 reset flags",
            int'({tmux, pulse, done, verdict, sticky}), 0);
        chk(code == '0, "R1 reset code", int'(code), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({tmux, pulse, done} == 3'b0, "R1 idle after reset", int'({tmux, pulse, done}), 0);

        en = 1'b1;
        for (int i = 0; i < 8; i++) run_test(i);   // R9 order and eop wrap

        // R10: drop enable while the next test runs
        en = 1'b0;
        run_test(8);
        begin
            bit quiet = 1;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (tmux || pulse || done) quiet = 0;
            end
            chk(quiet, "R10 idle while disabled", int'(quiet), 1);
        end
        en = 1'b1;
        run_test(9);

        // R11: reset in mid-sequence
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(sticky == 1'b0, "R11 sticky cleared", int'(sticky), 0);
        chk({tmux, pulse, done, verdict} == 4'b0, "R11 reset flags",
            int'({tmux, pulse, done, verdict}), 0);
        rst = 1'b0;
        run_test(10);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule